// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 16K one-bit words. The host raises a request strobe with a read/write select, a 14-bit address and one bit of write data. The sequencer then steps the memory pins through a fixed order, one clock per step. It returns a one-cycle completion pulse and, for reads, the bit it captured.

The memory side has a registered address bus, a dedicated input data line, a separate output data line from the RAM, and three active-low controls: select, write strobe and output strobe. Each access presents the address first. A write then drives its data. After that the chip is selected, and the write or output strobe is asserted last. On release, the strobe rises while the chip is still selected, and the select rises one cycle later. The address and data stay put for the whole time the chip is selected. The RAM keeps its contents without refresh, so the sequencer only ever runs host accesses. A busy flag tells the host when a new request can be taken. Requests that arrive while busy are dropped.

Top module: `asram_seq`

## Requirements
- R1: While reset is held and after its release, `ram_cs_n`, `ram_we_n` and `ram_oe_n` are 1, `ram_addr` is 0, `ram_din` is 0, `rdata` is 0, and `done` and `busy` are 0.
- R2: A write accepted at clock edge k puts the address on `ram_addr` after edge k. It drives `ram_din` after edge k+1, pulls `ram_cs_n` low after edge k+2, and holds `ram_we_n` low for exactly the cycle after edge k+3.
- R3: A read accepted at edge k puts the address out after edge k and pulls `ram_cs_n` low after edge k+1. It then holds `ram_oe_n` low for the two cycles after edges k+2 and k+3, and captures `ram_dout` into `rdata` at edge k+4.
- R4: `rdata` changes only at the end of a read. Between reads, and during writes, it keeps the last captured bit.
- R5: `ram_we_n` and `ram_oe_n` are never low in the same cycle.
- R6: In the release cycle (after edge k+4), both strobes are high and `ram_cs_n` is still low. `ram_cs_n` returns high after edge k+5.
- R7: `ram_addr` and `ram_din` do not change while `ram_cs_n` is low.
- R8: `busy` is 1 from edge k until edge k+5. A request sampled while `busy` is 1 is ignored and leaves the memory pins untouched.
- R9: `done` is high for exactly one cycle per accepted access: the release cycle.
- R10: A strobe is low only while `ram_cs_n` is low. `ram_cs_n` falls only when both strobes are high.
- R11: A write never lowers `ram_oe_n`. A read never lowers `ram_we_n` and never changes `ram_din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 1 | Bit to write |
| rdata | output | 1 | Last bit read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Access in progress; requests ignored |
| ram_addr | output | ADDR_W | Memory address bus |
| ram_cs_n | output | 1 | Chip select, active low |
| ram_we_n | output | 1 | Write strobe, active low |
| ram_oe_n | output | 1 | Output strobe, active low |
| ram_din | output | 1 | Data line into the memory |
| ram_dout | input | 1 | Data line from the memory |

## Verification
Every access takes six cycles from the edge that accepts it. The address follows that edge, the select follows edge k+1 for a read or k+2 for a write, and the strobe follows one edge later. `done` and a new `rdata` appear after edge k+4, and the pins are idle again after edge k+5. The bench drives the request half a cycle before the accepting edge. It then takes one snapshot of the control pins, `done` and `busy` at each of the six following falling edges and compares each snapshot with the expected pattern for that cycle. The memory model returns the inverted bit whenever output enable is high, so a capture made too early shows up as a wrong `rdata`.

// File: rtl/asram_seq.sv
module asram_seq #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rdata,
  output logic              done,
  output logic              busy,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_cs_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic              ram_din,
  input  logic              ram_dout
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_DATA, S_SEL, S_STB, S_HOLD, S_REL
  } state_t;

  state_t st;
  logic   wr_q;
  logic   wd_q;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      wr_q     <= 1'b0;
      wd_q     <= 1'b0;
      rdata    <= 1'b0;
      done     <= 1'b0;
      ram_addr <= '0;
      ram_cs_n <= 1'b1;
      ram_we_n <= 1'b1;
      ram_oe_n <= 1'b1;
      ram_din  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          st       <= S_ADDR;
          wr_q     <= req_wr;
          wd_q     <= req_wdata;
          ram_addr <= req_addr;
        end
        S_ADDR: if (wr_q) begin
          st      <= S_DATA;
          ram_din <= wd_q;
        end else begin
          st       <= S_SEL;
          ram_cs_n <= 1'b0;
        end
        S_DATA: begin
          st       <= S_SEL;
          ram_cs_n <= 1'b0;
        end
        S_SEL: begin
          st <= S_STB;
          if (wr_q) ram_we_n <= 1'b0;
          else      ram_oe_n <= 1'b0;
        end
        S_STB: if (wr_q) begin
          st       <= S_REL;
          ram_we_n <= 1'b1;
          done     <= 1'b1;
        end else begin
          st <= S_HOLD;
        end
        S_HOLD: begin
          st       <= S_REL;
          rdata    <= ram_dout;
          ram_oe_n <= 1'b1;
          done     <= 1'b1;
        end
        S_REL: begin
          st       <= S_IDLE;
          ram_cs_n <= 1'b1;
          done     <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/asram_seq_chk.sv
module asram_seq_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              busy,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_cs_n,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic              ram_din
);

  p_excl_strobes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ram_we_n && !ram_oe_n));

  p_bus_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_cs_n && $past(!ram_cs_n)) |-> ($stable(ram_addr) && $stable(ram_din)));

  p_strobe_in_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we_n || !ram_oe_n) |-> !ram_cs_n);

  p_sel_falls_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_cs_n) |-> (ram_we_n && ram_oe_n));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ram_cs_n && ram_we_n && ram_oe_n));

  p_sel_rises_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ram_cs_n);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

bind asram_seq asram_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .busy(busy),
  .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
  .ram_oe_n(ram_oe_n), .ram_din(ram_din)
);

// File: tb/tb_asram_seq.sv
module tb_asram_seq;
  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, req_wr = 1'b0, req_wdata = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          rdata, done, busy, ram_cs_n, ram_we_n, ram_oe_n, ram_din, ram_dout;
  logic [AW-1:0] ram_addr;

  int checks = 0, fails = 0;
  int v_excl = 0, v_stab = 0, v_sel = 0;
  bit finished = 0;

  bit mem [int];

  always #2 clk = ~clk;

  asram_seq #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rdata(rdata), .done(done), .busy(busy),
    .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
    .ram_oe_n(ram_oe_n), .ram_din(ram_din), .ram_dout(ram_dout)
  );

  function automatic bit mem_rd(input logic [AW-1:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 1'b0;
  endfunction

  assign ram_dout = (!ram_cs_n && !ram_oe_n) ? mem_rd(ram_addr) : ~mem_rd(ram_addr);

  always @(posedge ram_we_n)
    if (rst_n && !ram_cs_n) mem[int'(ram_addr)] = ram_din;

  logic [AW-1:0] p_addr;
  logic          p_din, p_cs_n;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ram_we_n && !ram_oe_n) v_excl++;
      if (!p_cs_n && !ram_cs_n && (ram_addr !== p_addr || ram_din !== p_din)) v_stab++;
      if ((!ram_we_n || !ram_oe_n) && ram_cs_n) v_sel++;
    end
    p_addr = ram_addr; p_din = ram_din; p_cs_n = ram_cs_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] expv(input bit wr, input int i);
    logic [4:0] w [6] = '{5'b11101, 5'b11101, 5'b01101, 5'b00101, 5'b01111, 5'b11100};
    logic [4:0] r [6] = '{5'b11101, 5'b01101, 5'b01001, 5'b01001, 5'b01111, 5'b11100};
    return wr ? w[i] : r[i];
  endfunction

  task automatic access(input bit wr, input logic [AW-1:0] a, input bit d);
    logic [4:0] got;
    bit din0, rd0;
    @(negedge clk);
    din0 = ram_din; rd0 = rdata;
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 0) begin
        req = 1'b0;
        chk(ram_addr == a, wr ? "R2 address first" : "R3 address first", int'(ram_addr), int'(a));
      end
      got = {ram_cs_n, ram_we_n, ram_oe_n, done, busy};
      chk(got == expv(wr, i), wr ? "R2/R6/R8/R9 write phase" : "R3/R6/R8/R9 read phase",
          int'(got), int'(expv(wr, i)));
      if (wr && i == 1) chk(ram_din == d, "R2 data before select", int'(ram_din), int'(d));
      if (wr && i == 3) chk(rdata == rd0, "R4 rdata held in write", int'(rdata), int'(rd0));
      if (!wr && i == 4) chk(rdata == mem_rd(a), "R3 read capture", int'(rdata), int'(mem_rd(a)));
      if (!wr && i == 4) chk(ram_din == din0, "R11 read leaves din", int'(ram_din), int'(din0));
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({ram_cs_n, ram_we_n, ram_oe_n} == 3'b111, "R1 strobes in reset", int'({ram_cs_n, ram_we_n, ram_oe_n}), 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ram_cs_n, ram_we_n, ram_oe_n} == 3'b111, "R1 strobes after reset", int'({ram_cs_n, ram_we_n, ram_oe_n}), 7);
    chk(ram_addr == '0 && ram_din == 1'b0, "R1 bus zero", int'({ram_addr, ram_din}), 0);
    chk({rdata, done, busy} == 3'b000, "R1 host side idle", int'({rdata, done, busy}), 0);
  endtask

  task automatic t_patterns;
    access(1, 14'h0000, 1);
    access(1, 14'h3FFF, 0);
    access(1, 14'h2AAA, 1);
    access(1, 14'h1555, 0);
    access(0, 14'h0000, 0);
    access(0, 14'h3FFF, 0);
    access(0, 14'h2AAA, 0);
    access(0, 14'h1555, 0);
    access(1, 14'h3FFF, 1);
    access(0, 14'h3FFF, 0);
    chk(rdata == 1'b1, "R2 overwrite read back", int'(rdata), 1);
  endtask

  task automatic t_hold;
    bit keep;
    access(0, 14'h2AAA, 0);
    keep = rdata;
    repeat (5) @(negedge clk);
    chk(rdata == keep, "R4 rdata held idle", int'(rdata), int'(keep));
    access(1, 14'h0123, ~keep);
    chk(rdata == keep, "R4 rdata held after write", int'(rdata), int'(keep));
  endtask

  task automatic t_busy_ignore;
    logic [AW-1:0] a = 14'h0A5A;
    @(negedge clk);
    req = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = 1'b1;
    @(negedge clk);
    req_wr = 1'b0; req_addr = 14'h3333;
    for (int i = 1; i < 6; i++) @(negedge clk);
    req = 1'b0;
    chk(ram_addr == a, "R8 busy request ignored addr", int'(ram_addr), int'(a));
    chk(ram_cs_n == 1'b1 && busy == 1'b0, "R8 no second access", int'({ram_cs_n, busy}), 2);
    repeat (4) begin
      @(negedge clk);
      chk(ram_cs_n == 1'b1 && done == 1'b0, "R8 pins untouched", int'({ram_cs_n, done}), 2);
    end
    access(0, a, 0);
    chk(rdata == 1'b1, "R8 first write took effect", int'(rdata), 1);
  endtask

  task automatic finish_run;
    chk(v_excl == 0, "R5 strobe overlap count", v_excl, 0);
    chk(v_stab == 0, "R7 bus change while selected", v_stab, 0);
    chk(v_sel == 0, "R10 strobe outside select", v_sel, 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_hold();
    t_busy_ignore();
    finish_run();
  end

  initial begin
    #800000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule